// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host that wants to touch PCI configuration space and a host bridge that offers two registers for this: an address register and a data port. It takes one request at a time (bus, device/function, register offset, access size, direction, write data, plus the vendor and device identity of the target). It turns the request into an address word, writes that word into the bridge's address register, and reads it back. The block keeps rewriting the word until the read-back agrees. Only then does it perform the data access on the correct byte lanes. A write is always followed by a read of the same data-port word, so that the write is known to have landed before the host sees a response.

Some requests never reach the bridge. A device slot on the bridge's own bus below device 11 is reported as missing. When the optional register filter is enabled, a window of registers of one particular target is refused. In both cases reads return all-ones of the requested size and the response carries an error status. The number of address read-back attempts is capped by a programmable count, so a bridge that never agrees produces a timeout status instead of a hang.

Top module: `cfg_access_xlate`

## Requirements
- R1: When `req_bus` equals `first_bus`, the address word is `(1 << dev) | (func << 8) | (off & 0xFC)`, where dev is `req_devfn[7:3]` and func is `req_devfn[2:0]`, so bits 1:0 are zero.
- R2: When `req_bus` equals `first_bus` and `req_devfn` is below 88, no bridge access is made. The response status is 01 (no device) and the data is all-ones of the size: 0xFF for size 00 (byte), 0xFFFF for size 01 (word), 0xFFFFFFFF for size 10 (dword). A write in this case changes nothing.
- R3: When `req_bus` differs from `first_bus`, the address word is `(bus << 16) | (devfn << 8) | (off & 0xFC) | 1`.
- R4: After each write of the address word, the address register is read back (`br_data_sel`=0). On a mismatch the word is written again. The data port (`br_data_sel`=1) is not accessed until a read-back matches.
- R5: If `retry_cap` read-backs in a row mismatch, the response status is 11 (timeout), the data port is never accessed, and the read data is all-ones of the size.
- R6: The data-port byte offset is `req_off & 7` when `wide_en`=1 and `req_off & 3` otherwise. Its bit 2 drives `br_word` and its bits 1:0 give the first lane. A byte uses one lane, a word two adjacent lanes, and a dword all four. Lane k carries bits 8k+7:8k, little-endian, and write data is shifted to the first lane.
- R7: Read data is taken from the selected lanes, right-aligned in `rsp_data`, with the bits above the access size zero. The status is 00 (success).
- R8: A data-port write is followed by a data-port read of the same word and lanes before the response is given.
- R9: With `filt_en`=1, a target with vendor 0x106B and device 0x0003 is refused for offsets 0x10 to 0x24 inclusive, except 0x14 and 0x18. A refused request makes no bridge access and gets status 10 (bad register) with all-ones read data. With `filt_en`=0, or outside that window, the request proceeds normally.
- R10: `req_ready` is high only when no request is in progress. Each accepted request produces exactly one single-cycle `rsp_valid` pulse. The bridge is never accessed while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_bus | input | 8 | Bus number of the bridge's own bus |
| wide_en | input | 1 | Data port is two words wide (offset mask 7 instead of 3) |
| filt_en | input | 1 | Enables the register-window filter |
| retry_cap | input | RETRY_W | Maximum number of address read-back attempts |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_off | input | 8 | Register byte offset |
| req_size | input | 2 | 00 byte, 01 word, 10 dword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| req_vendor | input | 16 | Vendor identity of the target |
| req_device | input | 16 | Device identity of the target |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Read data, right-aligned |
| rsp_status | output | 2 | 00 ok, 01 no device, 10 bad register, 11 timeout |
| br_req | output | 1 | Bridge access request, held until acknowledged |
| br_data_sel | output | 1 | 0 address register, 1 data port |
| br_we | output | 1 | Bridge access is a write |
| br_word | output | 1 | Upper word of a wide data port |
| br_be | output | 4 | Byte lane enables |
| br_wdata | output | 32 | Bridge write data |
| br_ack | input | 1 | Bridge access complete |
| br_rdata | input | 32 | Bridge read data, valid with `br_ack` |

## Verification
The bench builds the block with the default RETRY_W of 4, so caps up to 15 can be set at run time. This lets one run reach both recovery after a couple of mismatched read-backs and the timeout after three. The bench switches `first_bus`, `wide_en` and `filt_en` between requests on the same instance. Both offset masks, both address encodings, the device-11 boundary and every edge and hole of the filter window are therefore covered without rebuilding.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int BUS_W   = 8;
    localparam int DEVFN_W = 8;
    localparam int OFF_W   = 8;
    localparam int ID_W    = 16;
    localparam int LANES   = 4;
    localparam int DATA_W  = LANES * 8;
    localparam int LANE_W  = $clog2(LANES);

    localparam logic [ID_W-1:0]  FILT_VENDOR = 16'h106B;
    localparam logic [ID_W-1:0]  FILT_DEVICE = 16'h0003;
    localparam logic [OFF_W-1:0] FILT_LO     = 8'h10;
    localparam logic [OFF_W-1:0] FILT_HI     = 8'h24;
    localparam logic [OFF_W-1:0] FILT_HOLE_A = 8'h14;
    localparam logic [OFF_W-1:0] FILT_HOLE_B = 8'h18;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_NODEV   = 2'b01,
        ST_BADREG  = 2'b10,
        ST_TIMEOUT = 2'b11
    } status_e;

    typedef struct packed {
        logic [BUS_W-1:0]   bus;
        logic [DEVFN_W-1:0] devfn;
        logic [OFF_W-1:0]   off;
        size_e              size;
        logic               write;
        logic [DATA_W-1:0]  wdata;
        logic [ID_W-1:0]    vendor;
        logic [ID_W-1:0]    device;
    } req_t;

    function automatic logic [DATA_W-1:0] ones_for(size_e sz);
        case (sz)
            SZ_BYTE: return DATA_W'(8'hFF);
            SZ_WORD: return DATA_W'(16'hFFFF);
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

    function automatic logic [2:0] bytes_for(size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] local_word(logic [DEVFN_W-1:0] devfn,
                                                     logic [OFF_W-1:0] off);
        logic [DATA_W-1:0] w;
        w = DATA_W'(1) << devfn[7:3];
        w = w | (DATA_W'(devfn[2:0]) << 8);
        w = w | DATA_W'({off[7:2], 2'b00});
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] fwd_word(logic [BUS_W-1:0] bus,
                                                   logic [DEVFN_W-1:0] devfn,
                                                   logic [OFF_W-1:0] off);
        return {8'h00, bus, devfn, off[7:2], 2'b01};
    endfunction

endpackage

// File: rtl/cfgx_classify.sv
module cfgx_classify
    import cfgx_pkg::*;
#(
    parameter int MIN_LOCAL_DEV = 11
) (
    input  req_t               req,
    input  logic [BUS_W-1:0]   first_bus,
    input  logic               wide_en,
    input  logic               filt_en,
    output logic [DATA_W-1:0]  addr_word,
    output logic               absent,
    output logic               blocked,
    output logic [LANE_W-1:0]  lane,
    output logic               word_sel
);
    localparam logic [DEVFN_W-1:0] MIN_DEVFN = DEVFN_W'(MIN_LOCAL_DEV * 8);

    logic       on_local;
    logic [2:0] byte_off;
    logic       id_hit;
    logic       in_window;

    always_comb begin
        on_local  = (req.bus == first_bus);
        addr_word = on_local ? local_word(req.devfn, req.off)
                             : fwd_word(req.bus, req.devfn, req.off);
        absent    = on_local && (req.devfn < MIN_DEVFN);

        id_hit    = (req.vendor == FILT_VENDOR) && (req.device == FILT_DEVICE);
        in_window = (req.off >= FILT_LO) && (req.off <= FILT_HI) &&
                    (req.off != FILT_HOLE_A) && (req.off != FILT_HOLE_B);
        blocked   = filt_en && id_hit && in_window;

        byte_off  = req.off[2:0] & (wide_en ? 3'b111 : 3'b011);
        lane      = byte_off[LANE_W-1:0];
        word_sel  = byte_off[2];
    end
endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes
    import cfgx_pkg::*;
(
    input  logic [LANE_W-1:0] lane,
    input  size_e             size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata_raw,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_lane,
    output logic [DATA_W-1:0] rdata_out
);
    logic [2:0] nbytes;
    logic [4:0] shamt;

    assign nbytes = bytes_for(size);
    assign shamt  = {lane, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [2:0] idx;
        logic [2:0] rel;
        assign idx   = 3'(i);
        assign rel   = idx - {1'b0, lane};
        assign be[i] = ({1'b0, lane} <= idx) && (rel < nbytes);
    end

    assign wdata_lane = wdata << shamt;
    assign rdata_out  = (rdata_raw >> shamt) & ones_for(size);
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
    import cfgx_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RETRY_W-1:0] retry_cap,
    input  logic               req_valid,
    output logic               req_ready,
    input  req_t               req_in,
    output req_t               req_q,
    input  logic [DATA_W-1:0]  addr_word,
    input  logic               absent,
    input  logic               blocked,
    input  logic [LANES-1:0]   be,
    input  logic               word_sel,
    input  logic [DATA_W-1:0]  wdata_lane,
    input  logic [DATA_W-1:0]  rdata_out,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output status_e            rsp_status,
    output logic               br_req,
    output logic               br_data_sel,
    output logic               br_we,
    output logic               br_word,
    output logic [LANES-1:0]   br_be,
    output logic [DATA_W-1:0]  br_wdata,
    input  logic               br_ack,
    input  logic [DATA_W-1:0]  br_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_DECIDE, S_AWR, S_ARD, S_DACC, S_DUMMY, S_RESP
    } state_e;

    state_e             state;
    logic [RETRY_W-1:0] tries;

    assign req_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);

    always_comb begin
        br_req      = 1'b0;
        br_data_sel = 1'b0;
        br_we       = 1'b0;
        br_word     = 1'b0;
        br_be       = '1;
        br_wdata    = '0;
        case (state)
            S_AWR: begin
                br_req   = 1'b1;
                br_we    = 1'b1;
                br_wdata = addr_word;
            end
            S_ARD: begin
                br_req = 1'b1;
            end
            S_DACC: begin
                br_req      = 1'b1;
                br_data_sel = 1'b1;
                br_we       = req_q.write;
                br_word     = word_sel;
                br_be       = be;
                br_wdata    = req_q.write ? wdata_lane : '0;
            end
            S_DUMMY: begin
                br_req      = 1'b1;
                br_data_sel = 1'b1;
                br_word     = word_sel;
                br_be       = be;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            req_q      <= '0;
            tries      <= '0;
            rsp_data   <= '0;
            rsp_status <= ST_OK;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        state <= S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    if (blocked) begin
                        rsp_status <= ST_BADREG;
                        rsp_data   <= ones_for(req_q.size);
                        state      <= S_RESP;
                    end else if (absent) begin
                        rsp_status <= ST_NODEV;
                        rsp_data   <= ones_for(req_q.size);
                        state      <= S_RESP;
                    end else begin
                        tries <= RETRY_W'(1);
                        state <= S_AWR;
                    end
                end
                S_AWR: begin
                    if (br_ack) state <= S_ARD;
                end
                S_ARD: begin
                    if (br_ack) begin
                        if (br_rdata == addr_word) begin
                            state <= S_DACC;
                        end else if (tries >= retry_cap) begin
                            rsp_status <= ST_TIMEOUT;
                            rsp_data   <= ones_for(req_q.size);
                            state      <= S_RESP;
                        end else begin
                            tries <= tries + RETRY_W'(1);
                            state <= S_AWR;
                        end
                    end
                end
                S_DACC: begin
                    if (br_ack) begin
                        if (req_q.write) begin
                            state <= S_DUMMY;
                        end else begin
                            rsp_status <= ST_OK;
                            rsp_data   <= rdata_out;
                            state      <= S_RESP;
                        end
                    end
                end
                S_DUMMY: begin
                    if (br_ack) begin
                        rsp_status <= ST_OK;
                        rsp_data   <= '0;
                        state      <= S_RESP;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_access_xlate.sv
module cfg_access_xlate
    import cfgx_pkg::*;
#(
    parameter int RETRY_W       = 4,
    parameter int MIN_LOCAL_DEV = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         first_bus,
    input  logic               wide_en,
    input  logic               filt_en,
    input  logic [RETRY_W-1:0] retry_cap,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [7:0]         req_bus,
    input  logic [7:0]         req_devfn,
    input  logic [7:0]         req_off,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    input  logic [15:0]        req_vendor,
    input  logic [15:0]        req_device,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data,
    output logic [1:0]         rsp_status,
    output logic               br_req,
    output logic               br_data_sel,
    output logic               br_we,
    output logic               br_word,
    output logic [3:0]         br_be,
    output logic [31:0]        br_wdata,
    input  logic               br_ack,
    input  logic [31:0]        br_rdata
);
    req_t              req_in;
    req_t              req_q;
    logic [DATA_W-1:0] addr_word;
    logic              absent;
    logic              blocked;
    logic [LANE_W-1:0] lane;
    logic              word_sel;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] wdata_lane;
    logic [DATA_W-1:0] rdata_out;
    status_e           status;

    always_comb begin
        req_in.bus    = req_bus;
        req_in.devfn  = req_devfn;
        req_in.off    = req_off;
        req_in.size   = size_e'(req_size);
        req_in.write  = req_write;
        req_in.wdata  = req_wdata;
        req_in.vendor = req_vendor;
        req_in.device = req_device;
    end

    cfgx_classify #(.MIN_LOCAL_DEV(MIN_LOCAL_DEV)) u_classify (
        .req       (req_q),
        .first_bus (first_bus),
        .wide_en   (wide_en),
        .filt_en   (filt_en),
        .addr_word (addr_word),
        .absent    (absent),
        .blocked   (blocked),
        .lane      (lane),
        .word_sel  (word_sel)
    );

    cfgx_lanes u_lanes (
        .lane       (lane),
        .size       (req_q.size),
        .wdata      (req_q.wdata),
        .rdata_raw  (br_rdata),
        .be         (be),
        .wdata_lane (wdata_lane),
        .rdata_out  (rdata_out)
    );

    cfgx_seq #(.RETRY_W(RETRY_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .retry_cap   (retry_cap),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_in      (req_in),
        .req_q       (req_q),
        .addr_word   (addr_word),
        .absent      (absent),
        .blocked     (blocked),
        .be          (be),
        .word_sel    (word_sel),
        .wdata_lane  (wdata_lane),
        .rdata_out   (rdata_out),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_status  (status),
        .br_req      (br_req),
        .br_data_sel (br_data_sel),
        .br_we       (br_we),
        .br_word     (br_word),
        .br_be       (br_be),
        .br_wdata    (br_wdata),
        .br_ack      (br_ack),
        .br_rdata    (br_rdata)
    );

    assign rsp_status = status;
endmodule

// File: rtl/cfg_access_xlate_chk.sv
module cfg_access_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        br_req,
    input logic        br_data_sel,
    input logic        br_we,
    input logic [3:0]  br_be,
    input logic [31:0] br_wdata,
    input logic        br_ack,
    input logic [31:0] br_rdata
);
    logic [31:0] last_addr;
    logic        addr_ok;
    logic        pend_dummy;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr  <= '0;
            addr_ok    <= 1'b0;
            pend_dummy <= 1'b0;
        end else begin
            if (req_valid && req_ready) addr_ok <= 1'b0;
            if (br_req && br_ack && !br_data_sel && br_we) begin
                last_addr <= br_wdata;
                addr_ok   <= 1'b0;
            end
            if (br_req && br_ack && !br_data_sel && !br_we)
                addr_ok <= (br_rdata == last_addr);
            if (br_req && br_ack && br_data_sel)
                pend_dummy <= br_we;
        end
    end

    // R4
    data_after_match_chk: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_data_sel) |-> addr_ok);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (br_req && !br_ack) |=> (br_req && $stable(br_data_sel) && $stable(br_we)));

    // R8
    dummy_before_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !pend_dummy);

    // R6
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_data_sel) |->
            ($countones(br_be) == 1 || $countones(br_be) == 2 || $countones(br_be) == 4));

    // R10
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R10
    bridge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !br_req);

    // R10
    single_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind cfg_access_xlate cfg_access_xlate_chk u_chk (.*);

// File: tb/test_cfg_access_xlate.sv
module test_cfg_access_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    first_bus;
    logic          wide_en, filt_en;
    logic [RW-1:0] retry_cap;
    logic          req_valid, req_ready;
    logic [7:0]    req_bus, req_devfn, req_off;
    logic [1:0]    req_size;
    logic          req_write;
    logic [31:0]   req_wdata;
    logic [15:0]   req_vendor, req_device;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic [1:0]    rsp_status;
    logic          br_req, br_data_sel, br_we, br_word;
    logic [3:0]    br_be;
    logic [31:0]   br_wdata;
    logic          br_ack;
    logic [31:0]   br_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_xlate #(.RETRY_W(RW)) i_cfg_access_xlate (.*);

    // bridge model
    logic [31:0] areg;
    logic [31:0] mem [2];
    int n_addr_wr, n_addr_rd, n_data, n_dummy;
    int glitch_base = 0;
    int glitch_cfg = 0;
    logic last_wr_valid, last_wr_word;
    logic last_word;
    logic [3:0] last_be;

    always @(posedge clk) begin
        if (rst) begin
            br_ack <= 1'b0; br_rdata <= '0; areg <= '0;
            mem[0] <= 32'hA1B2C3D4; mem[1] <= 32'h0;
            n_addr_wr <= 0; n_addr_rd <= 0; n_data <= 0; n_dummy <= 0;
            last_wr_valid <= 1'b0; last_wr_word <= 1'b0;
            last_word <= 1'b0; last_be <= '0;
        end else begin
            br_ack <= br_req && !br_ack;
            if (br_req && !br_ack) begin
                if (!br_data_sel) begin
                    if (br_we) begin
                        areg <= br_wdata;
                        n_addr_wr <= n_addr_wr + 1;
                    end else begin
                        br_rdata <= ((n_addr_rd - glitch_base) < glitch_cfg) ? (areg ^ 32'h1) : areg;
                        n_addr_rd <= n_addr_rd + 1;
                    end
                end else begin
                    n_data <= n_data + 1;
                    last_word <= br_word;
                    last_be <= br_be;
                    if (br_we) begin
                        for (int k = 0; k < 4; k++)
                            if (br_be[k]) mem[br_word][8*k +: 8] <= br_wdata[8*k +: 8];
                        last_wr_valid <= 1'b1;
                        last_wr_word <= br_word;
                    end else begin
                        br_rdata <= mem[br_word];
                        if (last_wr_valid && last_wr_word == br_word) n_dummy <= n_dummy + 1;
                        last_wr_valid <= 1'b0;
                    end
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [7:0] bus, logic [7:0] devfn, logic [7:0] off,
                         logic [1:0] size, logic wr, logic [31:0] wd,
                         logic [15:0] ven, logic [15:0] dev,
                         output logic [31:0] data, output logic [1:0] st);
        int guard = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_bus = bus; req_devfn = devfn; req_off = off; req_size = size;
        req_write = wr; req_wdata = wd; req_vendor = ven; req_device = dev;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        data = rsp_data;
        st = rsp_status;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 ready after reset", 32'(req_ready), 32'd1);
        chk("R10 no response after reset", 32'(rsp_valid), 32'd0);
        chk("R10 bridge idle after reset", 32'(br_req), 32'd0);
    endtask

    task automatic t_local();
        logic [31:0] d; logic [1:0] s; int w0;
        w0 = n_addr_wr;
        issue(8'd0, {5'd13, 3'd2}, 8'h46, 2'b00, 1'b0, 0, 0, 0, d, s);
        chk("R1 local address word", areg, 32'h0000_2244);
        chk("R6 byte lane enable", 32'(last_be), 32'h4);
        chk("R7 byte read data", d, 32'h0000_00B2);
        chk("R7 ok status", 32'(s), 32'd0);
        chk("R4 single address write on match", 32'(n_addr_wr - w0), 32'd1);
        issue(8'd0, 8'h58, 8'h00, 2'b10, 1'b0, 0, 0, 0, d, s);
        chk("R2 device 11 present", 32'(s), 32'd0);
        chk("R1 device 11 address word", areg, 32'h0000_0800);
        chk("R7 dword read data", d, 32'hA1B2_C3D4);
    endtask

    task automatic t_forward();
        logic [31:0] d; logic [1:0] s; int dm;
        dm = n_dummy;
        wide_en = 1'b1;
        issue(8'd5, 8'h21, 8'h1E, 2'b01, 1'b1, 32'h0000_BEEF, 0, 0, d, s);
        chk("R3 forwarded address word", areg, 32'h0005_211D);
        chk("R6 wide offset selects upper word", 32'(last_word), 32'd1);
        chk("R6 word lane enables", 32'(last_be), 32'hC);
        chk("R8 dummy read after write", 32'(n_dummy - dm), 32'd1);
        chk("R7 write status", 32'(s), 32'd0);
        issue(8'd5, 8'h21, 8'h1C, 2'b10, 1'b0, 0, 0, 0, d, s);
        chk("R6 little-endian write placement", d, 32'hBEEF_0000);
        wide_en = 1'b0;
        issue(8'd5, 8'h21, 8'h1E, 2'b01, 1'b0, 0, 0, 0, d, s);
        chk("R6 normal mode masks bit 2", 32'(last_word), 32'd0);
        chk("R7 word read data", d, 32'h0000_A1B2);
    endtask

    task automatic t_absent();
        logic [31:0] d; logic [1:0] s; int w0, n0;
        first_bus = 8'd3;
        w0 = n_addr_wr; n0 = n_data;
        issue(8'd3, 8'h57, 8'h00, 2'b00, 1'b0, 0, 0, 0, d, s);
        chk("R2 absent byte data", d, 32'h0000_00FF);
        chk("R2 absent status", 32'(s), 32'd1);
        issue(8'd3, 8'h00, 8'h02, 2'b01, 1'b0, 0, 0, 0, d, s);
        chk("R2 absent word data", d, 32'h0000_FFFF);
        issue(8'd3, 8'h30, 8'h04, 2'b10, 1'b0, 0, 0, 0, d, s);
        chk("R2 absent dword data", d, 32'hFFFF_FFFF);
        issue(8'd3, 8'h57, 8'h00, 2'b10, 1'b1, 32'h1234_5678, 0, 0, d, s);
        chk("R2 absent write status", 32'(s), 32'd1);
        chk("R2 no address writes", 32'(n_addr_wr - w0), 32'd0);
        chk("R2 no data accesses", 32'(n_data - n0), 32'd0);
        issue(8'd3, 8'h58, 8'h00, 2'b10, 1'b0, 0, 0, 0, d, s);
        chk("R2 dword data unchanged by dropped write", d, 32'hA1B2_C3D4);
        issue(8'd4, 8'h00, 8'h08, 2'b10, 1'b0, 0, 0, 0, d, s);
        chk("R3 other bus not subject to device limit", 32'(s), 32'd0);
        chk("R3 other bus address word", areg, 32'h0004_0009);
        first_bus = 8'd0;
    endtask

    task automatic t_retry();
        logic [31:0] d; logic [1:0] s; int w0, n0;
        retry_cap = 4'd4;
        glitch_base = n_addr_rd; glitch_cfg = 2;
        w0 = n_addr_wr;
        issue(8'd0, 8'h58, 8'h44, 2'b00, 1'b0, 0, 0, 0, d, s);
        chk("R4 address rewritten until match", 32'(n_addr_wr - w0), 32'd3);
        chk("R4 data after recovery", d, 32'h0000_00D4);
        chk("R4 status after recovery", 32'(s), 32'd0);
        retry_cap = 4'd3;
        glitch_base = n_addr_rd; glitch_cfg = 9;
        w0 = n_addr_wr; n0 = n_data;
        issue(8'd0, 8'h58, 8'h00, 2'b01, 1'b0, 0, 0, 0, d, s);
        chk("R5 timeout status", 32'(s), 32'd3);
        chk("R5 attempts limited by cap", 32'(n_addr_wr - w0), 32'd3);
        chk("R5 data port untouched", 32'(n_data - n0), 32'd0);
        chk("R5 timeout read data", d, 32'h0000_FFFF);
        glitch_cfg = 0;
        retry_cap = 4'd4;
    endtask

    task automatic t_filter();
        logic [31:0] d; logic [1:0] s; int w0;
        filt_en = 1'b1;
        w0 = n_addr_wr;
        issue(8'd0, 8'h60, 8'h10, 2'b10, 1'b0, 0, 16'h106B, 16'h0003, d, s);
        chk("R9 window low edge refused", 32'(s), 32'd2);
        chk("R9 refused read data", d, 32'hFFFF_FFFF);
        issue(8'd0, 8'h60, 8'h24, 2'b00, 1'b1, 32'h55, 16'h106B, 16'h0003, d, s);
        chk("R9 window high edge refused", 32'(s), 32'd2);
        chk("R9 no bridge access when refused", 32'(n_addr_wr - w0), 32'd0);
        issue(8'd0, 8'h60, 8'h14, 2'b10, 1'b0, 0, 16'h106B, 16'h0003, d, s);
        chk("R9 hole 0x14 passes", 32'(s), 32'd0);
        issue(8'd0, 8'h60, 8'h18, 2'b10, 1'b0, 0, 16'h106B, 16'h0003, d, s);
        chk("R9 hole 0x18 passes", 32'(s), 32'd0);
        issue(8'd0, 8'h60, 8'h28, 2'b10, 1'b0, 0, 16'h106B, 16'h0003, d, s);
        chk("R9 above window passes", 32'(s), 32'd0);
        issue(8'd0, 8'h60, 8'h0C, 2'b10, 1'b0, 0, 16'h106B, 16'h0003, d, s);
        chk("R9 below window passes", 32'(s), 32'd0);
        issue(8'd0, 8'h60, 8'h10, 2'b10, 1'b0, 0, 16'h106B, 16'h0004, d, s);
        chk("R9 other device passes", 32'(s), 32'd0);
        filt_en = 1'b0;
        issue(8'd0, 8'h60, 8'h10, 2'b10, 1'b0, 0, 16'h106B, 16'h0003, d, s);
        chk("R9 filter disabled passes", 32'(s), 32'd0);
    endtask

    initial begin
        rst = 1'b1; first_bus = 8'd0; wide_en = 1'b0; filt_en = 1'b0;
        retry_cap = 4'd4; req_valid = 1'b0; req_bus = 0; req_devfn = 0;
        req_off = 0; req_size = 0; req_write = 0; req_wdata = 0;
        req_vendor = 0; req_device = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_local();
        t_forward();
        t_absent();
        t_retry();
        t_filter();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule